// File: doc/BRIEF.md
# Double-Rate Prefetch Data Path with Strobe

This block is the data path that sits on the controller side of a double-data-rate memory interface. The core side moves one word of twice the pin width each core cycle. The pin side moves two beats of pin width per core cycle. On writes it splits each wide word into a lower beat followed by an upper beat. It drives a per-byte mask with each beat, and it drives a strobe that is parked low for a preamble before the data and a postamble after it. On reads it samples the incoming beats inside a window that opens only for the programmed burst, and it pairs them back into wide words. The window starts two or two and a half core cycles after the read command.

All logic runs on a single fast clock at twice the core rate. Each fast cycle is one beat. A phase bit inside the block marks which fast edges are core-cycle boundaries, and the block brings it out as `core_edge`. The quarter-cycle offsets between strobe and data are assumed to be done outside the block. On writes a fixed pad delay centres the strobe in each beat. On reads the fast clock edge already falls in the middle of each edge-aligned beat. Command timing, delay-locked loops and delay trimming belong to other blocks.

Top module: `ddr_pf_datapath`

## Requirements
- R1: While reset is high and after it is released, `dq_oe`, `dqs_oe` and `rd_valid` are low and `rd_word` is zero.
- R2: A write accepted at fast edge E0 drives the strobe low with `dqs_oe` high and `dq_oe` low during the two fast cycles after E0 and E1. This is the one-core-cycle preamble.
- R3: Beat k of a write appears on `dq_out` with `dq_oe` high in the fast cycle after edge E(2+k). Even beats carry bits [BEAT_W-1:0] of wide word k/2 and odd beats carry the upper half. `wr_take` is high in the fast cycle before the edge that latches each word.
- R4: During write beats `dqs_out` is 1 on even beats and 0 on odd beats, so it toggles every beat.
- R5: `dm_out` carries the lower MASK_W bits of the mask with even beats and the upper MASK_W bits with odd beats. A 1 means the byte is not to be written.
- R6: After the last write beat the strobe is driven low with `dq_oe` low for exactly one fast cycle. After that, `dqs_oe` and `dq_oe` are both low.
- R7: Burst select 2'b00, 2'b01 and 2'b10 give 2, 4 and 8 beats. The value 2'b11 also gives 8. A burst takes beats/2 wide words.
- R8: `wr_start` and `rd_start` are acted on only at an edge where `core_edge` was high in the cycle before and the path is idle. Otherwise they are ignored.
- R9: With `rd_cl_half` low, read beat k is sampled at edge E(4+k) after command edge E0. With `rd_cl_half` high it is sampled at E(5+k).
- R10: After the edge that samples an odd beat k, `rd_valid` pulses for one fast cycle. In that cycle `rd_word` = {beat k, beat k-1}.
- R11: Values on `dq_in` and `dqs_in` at edges outside the read window raise no `rd_valid` and leave `rd_word` unchanged.
- R12: A read pair is accepted only if `dqs_in` is 1 at its even beat and 0 at its odd beat. Otherwise the pair is dropped with no `rd_valid` and `rd_word` keeps its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, two edges per core cycle |
| rst | input | 1 | Synchronous active-high reset |
| core_edge | output | 1 | High when the next edge is a core-cycle boundary |
| wr_start | input | 1 | Write burst request |
| wr_burst | input | 2 | Write burst select |
| wr_word | input | 2*BEAT_W | Wide write word |
| wr_mask | input | 2*MASK_W | Byte mask for the wide word |
| wr_take | output | 1 | Wide word is latched at the next edge |
| dq_out | output | BEAT_W | Write beat to pins |
| dq_oe | output | 1 | Data pin drive enable |
| dm_out | output | MASK_W | Per-byte write mask to pins |
| dqs_out | output | 1 | Write strobe level |
| dqs_oe | output | 1 | Strobe pin drive enable |
| rd_start | input | 1 | Read burst request |
| rd_burst | input | 2 | Read burst select |
| rd_cl_half | input | 1 | 0: latency 2, 1: latency 2.5 |
| dq_in | input | BEAT_W | Read beat from pins |
| dqs_in | input | 1 | Returned read strobe |
| rd_word | output | 2*BEAT_W | Assembled wide read word |
| rd_valid | output | 1 | One-cycle pulse per assembled word |

## Verification
The hardest case to reach is a read pair whose strobe is wrong inside an open window, followed by a good pair in the same burst. Only this case shows that the drop affects one pair and does not stall the burst. The bench writes each beat and its strobe level one fast cycle before the edge that samples it. It inverts the strobe on a chosen beat, so the dropped pair and the good pair after it fall in the same eight-beat burst at latency 2.5. Around the window it puts strobe and data noise that would form valid pairs if the window were too wide.

// File: rtl/ddr_pf_pkg.sv
package ddr_pf_pkg;

    // Counter width covers read latency 2.5 (five beats) plus eight beats.
    localparam int IDX_W = 4;

    // Fast edges from the read command to the first sampled beat.
    localparam int RD_FIRST_FULL = 4;
    localparam int RD_FIRST_HALF = 5;

    // Fast cycles of strobe preamble ahead of the first write beat.
    localparam int WR_PRE_CYC = 2;

    typedef enum logic [1:0] {
        BURST_2  = 2'b00,
        BURST_4  = 2'b01,
        BURST_8  = 2'b10,
        BURST_8X = 2'b11
    } burst_e;

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] last;
    } seq_t;

    function automatic logic [IDX_W-1:0] burst_beats(input logic [1:0] sel);
        case (burst_e'(sel))
            BURST_2: return IDX_W'(2);
            BURST_4: return IDX_W'(4);
            default: return IDX_W'(8);
        endcase
    endfunction

endpackage

// File: rtl/ddr_pf_wr_path.sv
module ddr_pf_wr_path
    import ddr_pf_pkg::*;
#(
    parameter int BEAT_W = 16,
    parameter int MASK_W = BEAT_W / 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [1:0]            burst_sel,
    input  logic [2*BEAT_W-1:0]   word_in,
    input  logic [2*MASK_W-1:0]   mask_in,
    output logic                  take,
    output logic [BEAT_W-1:0]     dq,
    output logic                  dq_en,
    output logic [MASK_W-1:0]     dm,
    output logic                  dqs,
    output logic                  dqs_en
);

    localparam logic [IDX_W-1:0] PRE_END = IDX_W'(WR_PRE_CYC);

    seq_t                seq_q;
    logic [2*BEAT_W-1:0] hold_q;
    logic [2*MASK_W-1:0] mhold_q;
    logic                in_data;
    logic                upper;

    // The last index is the postamble cycle: preamble + beats.
    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q   <= '0;
            hold_q  <= '0;
            mhold_q <= '0;
        end else begin
            if (!seq_q.busy) begin
                if (start) begin
                    seq_q.busy <= 1'b1;
                    seq_q.idx  <= '0;
                    seq_q.last <= burst_beats(burst_sel) + PRE_END;
                end
            end else begin
                if (seq_q.idx == seq_q.last) begin
                    seq_q.busy <= 1'b0;
                end
                seq_q.idx <= seq_q.idx + 1'b1;
            end
            if (take) begin
                hold_q  <= word_in;
                mhold_q <= mask_in;
            end
        end
    end

    // A word is latched at the edge that starts each even beat.
    assign take    = seq_q.busy && seq_q.idx[0] && ((seq_q.idx + 1'b1) < seq_q.last);
    assign in_data = seq_q.busy && (seq_q.idx >= PRE_END) && (seq_q.idx < seq_q.last);
    assign upper   = seq_q.idx[0];

    assign dq     = !in_data ? '0 : (upper ? hold_q[2*BEAT_W-1:BEAT_W] : hold_q[BEAT_W-1:0]);
    assign dm     = !in_data ? '0 : (upper ? mhold_q[2*MASK_W-1:MASK_W] : mhold_q[MASK_W-1:0]);
    assign dq_en  = in_data;
    assign dqs    = in_data && !upper;
    assign dqs_en = seq_q.busy;

endmodule

// File: rtl/ddr_pf_rd_path.sv
module ddr_pf_rd_path
    import ddr_pf_pkg::*;
#(
    parameter int BEAT_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                cl_half,
    input  logic [1:0]          burst_sel,
    input  logic [BEAT_W-1:0]   dq_in,
    input  logic                dqs_in,
    output logic [2*BEAT_W-1:0] word,
    output logic                valid
);

    logic             busy_q;
    logic [IDX_W-1:0] cnt_q;
    logic [IDX_W-1:0] first_q;
    logic [IDX_W-1:0] last_q;
    logic [IDX_W-1:0] first_n;
    logic [BEAT_W-1:0] low_q;
    logic             low_ok_q;
    logic [2*BEAT_W-1:0] word_q;
    logic             valid_q;
    logic             window;
    logic             odd_beat;

    assign first_n  = cl_half ? IDX_W'(RD_FIRST_HALF) : IDX_W'(RD_FIRST_FULL);
    assign window   = busy_q && (cnt_q >= first_q) && (cnt_q <= last_q);
    assign odd_beat = cnt_q[0] ^ first_q[0];

    // cnt_q equals n at edge En after the command edge E0.
    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            cnt_q    <= '0;
            first_q  <= '0;
            last_q   <= '0;
            low_q    <= '0;
            low_ok_q <= 1'b0;
            word_q   <= '0;
            valid_q  <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    busy_q  <= 1'b1;
                    cnt_q   <= IDX_W'(1);
                    first_q <= first_n;
                    last_q  <= first_n + burst_beats(burst_sel) - 1'b1;
                end
            end else begin
                if (cnt_q == last_q) begin
                    busy_q <= 1'b0;
                end
                cnt_q <= cnt_q + 1'b1;
            end
            if (window) begin
                if (!odd_beat) begin
                    low_q    <= dq_in;
                    low_ok_q <= dqs_in;
                end else if (low_ok_q && !dqs_in) begin
                    word_q  <= {dq_in, low_q};
                    valid_q <= 1'b1;
                end
            end
        end
    end

    assign word  = word_q;
    assign valid = valid_q;

endmodule

// File: rtl/ddr_pf_datapath.sv
module ddr_pf_datapath
    import ddr_pf_pkg::*;
#(
    parameter int BEAT_W = 16,
    parameter int MASK_W = BEAT_W / 8
) (
    input  logic                  clk,
    input  logic                  rst,
    output logic                  core_edge,
    input  logic                  wr_start,
    input  logic [1:0]            wr_burst,
    input  logic [2*BEAT_W-1:0]   wr_word,
    input  logic [2*MASK_W-1:0]   wr_mask,
    output logic                  wr_take,
    output logic [BEAT_W-1:0]     dq_out,
    output logic                  dq_oe,
    output logic [MASK_W-1:0]     dm_out,
    output logic                  dqs_out,
    output logic                  dqs_oe,
    input  logic                  rd_start,
    input  logic [1:0]            rd_burst,
    input  logic                  rd_cl_half,
    input  logic [BEAT_W-1:0]     dq_in,
    input  logic                  dqs_in,
    output logic [2*BEAT_W-1:0]   rd_word,
    output logic                  rd_valid
);

    logic phase_q;

    // Phase 0 marks the edge that begins a core cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= 1'b0;
        end else begin
            phase_q <= ~phase_q;
        end
    end

    assign core_edge = ~phase_q;

    ddr_pf_wr_path #(
        .BEAT_W (BEAT_W),
        .MASK_W (MASK_W)
    ) wr_i (
        .clk       (clk),
        .rst       (rst),
        .start     (wr_start && !phase_q),
        .burst_sel (wr_burst),
        .word_in   (wr_word),
        .mask_in   (wr_mask),
        .take      (wr_take),
        .dq        (dq_out),
        .dq_en     (dq_oe),
        .dm        (dm_out),
        .dqs       (dqs_out),
        .dqs_en    (dqs_oe)
    );

    ddr_pf_rd_path #(
        .BEAT_W (BEAT_W)
    ) rd_i (
        .clk       (clk),
        .rst       (rst),
        .start     (rd_start && !phase_q),
        .cl_half   (rd_cl_half),
        .burst_sel (rd_burst),
        .dq_in     (dq_in),
        .dqs_in    (dqs_in),
        .word      (rd_word),
        .valid     (rd_valid)
    );

endmodule

// File: rtl/ddr_pf_datapath_chk.sv
module ddr_pf_datapath_chk (
    input logic clk,
    input logic rst,
    input logic core_edge,
    input logic dq_oe,
    input logic dqs_oe,
    input logic dqs_out,
    input logic rd_valid
);

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!dq_oe && !dqs_oe && !rd_valid));

    // R2
    preamble_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dqs_oe) |-> (!dq_oe && !dqs_out));

    // R2
    preamble_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dqs_oe) |=> (dqs_oe && !dq_oe && !dqs_out));

    // R4
    strobe_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (dq_oe && $past(dq_oe)) |-> (dqs_out != $past(dqs_out)));

    // R6
    postamble_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(dq_oe) |-> (dqs_oe && !dqs_out));

    // R6
    release_chk: assert property (@(posedge clk) disable iff (rst)
        (dqs_oe && !dq_oe && $past(dq_oe)) |=> !dqs_oe);

    // R8
    phase_align_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dqs_oe) |-> !core_edge);

    // R10
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

endmodule

bind ddr_pf_datapath ddr_pf_datapath_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .core_edge (core_edge),
    .dq_oe     (dq_oe),
    .dqs_oe    (dqs_oe),
    .dqs_out   (dqs_out),
    .rd_valid  (rd_valid)
);

// File: tb/ddr_pf_datapath_tb.sv
module ddr_pf_datapath_tb_top;

    localparam int CLK_P = 10;
    localparam int BW    = 16;
    localparam int MW    = BW / 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            core_edge;
    logic            wr_start = 1'b0;
    logic [1:0]      wr_burst = 2'b00;
    logic [2*BW-1:0] wr_word = '0;
    logic [2*MW-1:0] wr_mask = '0;
    logic            wr_take;
    logic [BW-1:0]   dq_out;
    logic            dq_oe;
    logic [MW-1:0]   dm_out;
    logic            dqs_out;
    logic            dqs_oe;
    logic            rd_start = 1'b0;
    logic [1:0]      rd_burst = 2'b00;
    logic            rd_cl_half = 1'b0;
    logic [BW-1:0]   dq_in = '0;
    logic            dqs_in = 1'b0;
    logic [2*BW-1:0] rd_word;
    logic            rd_valid;

    int n_chk = 0;
    int n_bad = 0;
    logic [2*BW-1:0] exp_rword = '0;

    always #(CLK_P/2) clk = ~clk;

    ddr_pf_datapath #(.BEAT_W(BW)) dut_i (
        .clk(clk), .rst(rst), .core_edge(core_edge),
        .wr_start(wr_start), .wr_burst(wr_burst), .wr_word(wr_word),
        .wr_mask(wr_mask), .wr_take(wr_take), .dq_out(dq_out), .dq_oe(dq_oe),
        .dm_out(dm_out), .dqs_out(dqs_out), .dqs_oe(dqs_oe),
        .rd_start(rd_start), .rd_burst(rd_burst), .rd_cl_half(rd_cl_half),
        .dq_in(dq_in), .dqs_in(dqs_in), .rd_word(rd_word), .rd_valid(rd_valid)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int beats_of(input logic [1:0] sel);
        return (sel == 2'b00) ? 2 : (sel == 2'b01) ? 4 : 8;
    endfunction

    task automatic sync_core();
        @(negedge clk);
        while (!core_edge) @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!dq_oe && !dqs_oe && !rd_valid, "R1", "outputs in reset",
            {dq_oe, dqs_oe, rd_valid}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!dq_oe && !dqs_oe && !rd_valid && rd_word == '0, "R1", "after release",
            {dq_oe, dqs_oe, rd_valid, rd_word}, 0);
    endtask

    task automatic t_write(input logic [1:0] bsel, input logic [7:0] seed);
        int nb = beats_of(bsel);
        int wi = 0;
        logic [2*BW-1:0] words [4];
        logic [2*MW-1:0] masks [4];
        for (int j = 0; j < 4; j++) begin
            words[j] = {seed, 8'(j), ~seed, 8'(j * 3 + 1)};
            masks[j] = 4'(seed[3:0] + 4'(j * 5));
        end
        sync_core();
        wr_burst = bsel;
        wr_start = 1'b1;
        for (int n = 0; n <= 3 + nb; n++) begin
            @(posedge clk);
            @(negedge clk);
            wr_start = 1'b0;
            if (n < 2) begin
                chk(dqs_oe && !dqs_out && !dq_oe, "R2", "preamble",
                    {dqs_oe, dqs_out, dq_oe}, 3'b100);
            end else if (n < 2 + nb) begin
                int k = n - 2;
                logic [BW-1:0] ed = (k % 2 == 1) ? words[k/2][2*BW-1:BW] : words[k/2][BW-1:0];
                logic [MW-1:0] em = (k % 2 == 1) ? masks[k/2][2*MW-1:MW] : masks[k/2][MW-1:0];
                chk(dq_oe && dq_out == ed, "R3", "write beat data", {dq_oe, dq_out}, {1'b1, ed});
                chk(dqs_oe && dqs_out == (k % 2 == 0), "R4", "write strobe level",
                    dqs_out, (k % 2 == 0));
                chk(dm_out == em, "R5", "write mask beat", dm_out, em);
            end else if (n == 2 + nb) begin
                chk(dqs_oe && !dqs_out && !dq_oe, "R6", "postamble",
                    {dqs_oe, dqs_out, dq_oe}, 3'b100);
            end else begin
                chk(!dqs_oe && !dq_oe, "R6", "released", {dqs_oe, dq_oe}, 0);
            end
            if (wr_take) begin
                if (wi < 4) begin
                    wr_word = words[wi];
                    wr_mask = masks[wi];
                end
                wi++;
            end
        end
        chk(wi == nb / 2, "R7", "words taken per burst", wi, nb / 2);
    endtask

    task automatic t_read(input logic [1:0] bsel, input logic cl, input int bad_beat,
                          input logic [7:0] seed);
        int nb = beats_of(bsel);
        int first = cl ? 5 : 4;
        logic [BW-1:0] bd [8];
        for (int k = 0; k < 8; k++) bd[k] = BW'(seed * 256 + k * 17 + 5);
        sync_core();
        rd_burst   = bsel;
        rd_cl_half = cl;
        rd_start   = 1'b1;
        dq_in      = 16'hDEAD;
        dqs_in     = 1'b1;
        @(posedge clk);
        for (int n = 1; n <= first + nb + 2; n++) begin
            @(negedge clk);
            rd_start = 1'b0;
            if (n >= 2) begin
                int m = n - 1;
                int k = m - first;
                bit inwin = (k >= 0) && (k < nb);
                bit ev = inwin && (k % 2 == 1) && (bad_beat != k) && (bad_beat != k - 1);
                string tag = !inwin ? "R11" : ((bad_beat == k || bad_beat == k - 1) ? "R12" : "R9");
                if (ev) exp_rword = {bd[k], bd[k-1]};
                chk(rd_valid == ev, tag, "read valid timing", rd_valid, ev);
                chk(rd_word == exp_rword, ev ? "R10" : tag, "read word", rd_word, exp_rword);
            end
            begin
                int k = n - first;
                if (k >= 0 && k < nb) begin
                    dq_in  = bd[k];
                    dqs_in = (k % 2 == 0) ^ (bad_beat == k);
                end else begin
                    dq_in  = 16'hBEEF ^ BW'(n);
                    dqs_in = (n % 2 == 0);
                end
            end
            @(posedge clk);
        end
    endtask

    task automatic t_ignored_start();
        @(negedge clk);
        while (core_edge) @(negedge clk);
        wr_start = 1'b1;
        rd_start = 1'b1;
        rd_burst = 2'b01;
        rd_cl_half = 1'b0;
        @(posedge clk);
        @(negedge clk);
        wr_start = 1'b0;
        rd_start = 1'b0;
        for (int n = 0; n < 12; n++) begin
            dq_in  = BW'(16'h1234 + n);
            dqs_in = (n % 2 == 0);
            @(posedge clk);
            @(negedge clk);
            chk(!dqs_oe && !rd_valid && rd_word == exp_rword, "R8", "off-phase start ignored",
                {dqs_oe, rd_valid}, 0);
        end
    endtask

    initial begin
        #(CLK_P * 50000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_write(2'b00, 8'h3C);
        t_write(2'b01, 8'h5A);
        t_write(2'b10, 8'hC3);
        t_write(2'b11, 8'h81);
        t_ignored_start();
        t_read(2'b01, 1'b0, -1, 8'h11);
        t_read(2'b10, 1'b1, -1, 8'h22);
        t_read(2'b00, 1'b0, 1, 8'h33);
        t_read(2'b10, 1'b1, 2, 8'h44);
        t_read(2'b01, 1'b1, 0, 8'h55);
        repeat (4) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule